// File: doc/BRIEF.md
# Adapter Option Registers and Host Window Decoder

This block is the host-facing configuration front end of a network adapter. A bank of eight byte-wide I/O ports holds two fixed identification bytes, an enable register, a window base register and an interrupt-line selection. Software probes the identification bytes to find the card. It then writes the window base and sets the card-enable bit.

Once the card is enabled, the decoder watches the 20-bit host memory address. When the upper address bits match the programmed base, the access falls inside a 16 KB window. The decoder then raises exactly one region select and gives the offset within that region. The regions are:
- the shared packet RAM;
- an 8-bit station-address PROM that answers only on even bytes;
- a reserved gap;
- a two-byte data holding register, a control/status byte and a command byte at the top of the window.

For locations that hold no storage, the decoder also supplies a fixed read value.

Top module: `optsel_window`

## Requirements
- R1: I/O offset 0 reads 0xFD and offset 1 reads 0x6A. Writes to either offset leave those values unchanged.
- R2: I/O offset 2 is the enable register. Bit 0 = 1 turns the card on (`card_on`). Bit 1 = 1 turns the boot EPROM off, so `boot_rom_on` is the inverse of bit 1. Bits 1:0 read back as written, and bits 7:2 read 0.
- R3: I/O offset 3 holds the window base, host address bits 19:14, in bits 5:0. Bits 5:0 read back as written, and bits 7:6 read 0.
- R4: I/O offset 4 holds a 4-bit interrupt-line selection in bits 3:0. This field drives `irq_sel` and reads back as written. Bits 7:4 read 0.
- R5: After reset, all writable registers are 0. The card is therefore off, the boot EPROM is on, and the base and interrupt selection are 0.
- R6: I/O offsets 5 to 7 read 0x00. Writes to them change no register.
- R7: No region is selected and no fixed data is flagged unless the card is on and address bits 19:14 equal the base register.
- R8: Window offsets 0x0000–0x3FBF raise `win_sel` bit 0 (RAM). `win_off` equals the window offset.
- R9: Window offsets 0x3FC0–0x3FDF form the PROM region.
  - An even offset raises `win_sel` bit 1, and `win_off` equals (offset − 0x3FC0)/2, a value from 0 to 15.
  - An odd offset raises no select, sets `fix_en`, and gives `fix_data` = 0xFF.
- R10: Window offsets 0x3FE0–0x3FEF and 0x3FF4–0x3FFF are reserved. They raise `win_sel` bit 2, set `fix_en`, and give `fix_data` = 0x00.
- R11: The bridge registers decode as follows:
  - Offsets 0x3FF0–0x3FF1 raise `win_sel` bit 3, with `win_off` equal to 0 or 1.
  - Offset 0x3FF2 raises bit 4.
  - Offset 0x3FF3 raises bit 5.
- R12: At most one `win_sel` bit is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_cs | input | 1 | Access targets the option register bank |
| io_wr | input | 1 | Write strobe, qualified by io_cs |
| io_addr | input | 3 | Register offset within the bank |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for io_addr |
| mem_addr | input | 20 | Host memory address |
| card_on | output | 1 | Card-enable bit |
| boot_rom_on | output | 1 | Boot EPROM window enabled |
| irq_sel | output | 4 | Interrupt-line selection |
| win_sel | output | 6 | One-hot region select: RAM, PROM, reserved, hold, control, command |
| win_off | output | 14 | Offset within the selected region |
| fix_en | output | 1 | Location has a fixed read value |
| fix_data | output | 8 | Fixed read value |

## Verification
The bench builds the block with its default parameters: a 20-bit host address and a 16 KB window. With these, the 64-entry base register can be swept in full, and every base value is tried against a matching and a non-matching address.

The top 128 window offsets are swept byte by byte, with points inside the RAM region added. This reaches every boundary between RAM, PROM, the reserved gap and the bridge registers, as well as the even/odd split of the PROM.

All combinations of the enable bits and every interrupt-selection value are written and read back.

// File: rtl/optsel_pkg.sv
package optsel_pkg;
  localparam int NUM_REGION = 6;
  localparam int RG_RAM     = 0;
  localparam int RG_PROM    = 1;
  localparam int RG_RSVD    = 2;
  localparam int RG_HOLD    = 3;
  localparam int RG_CTRL    = 4;
  localparam int RG_CMD     = 5;

  localparam logic [2:0] OFS_ID_LO = 3'd0;
  localparam logic [2:0] OFS_ID_HI = 3'd1;
  localparam logic [2:0] OFS_ENA   = 3'd2;
  localparam logic [2:0] OFS_BASE  = 3'd3;
  localparam logic [2:0] OFS_IRQ   = 3'd4;

  localparam int ENA_CARD_BIT = 0;
  localparam int ENA_ROMOFF_BIT = 1;
endpackage

// File: rtl/optsel_regs.sv
module optsel_regs
  import optsel_pkg::*;
#(
  parameter int          BASE_W = 6,
  parameter int          IRQ_W  = 4,
  parameter logic [7:0]  ID_LO  = 8'hFD,
  parameter logic [7:0]  ID_HI  = 8'h6A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_cs,
  input  logic              io_wr,
  input  logic [2:0]        io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic [1:0]        ena_q,
  output logic [BASE_W-1:0] base_q,
  output logic [IRQ_W-1:0]  irq_q
);
  logic              wr_ena, wr_base, wr_irq;
  logic [1:0]        ena_d;
  logic [BASE_W-1:0] base_d;
  logic [IRQ_W-1:0]  irq_d;

  always_comb begin
    wr_ena  = io_cs && io_wr && (io_addr == OFS_ENA);
    wr_base = io_cs && io_wr && (io_addr == OFS_BASE);
    wr_irq  = io_cs && io_wr && (io_addr == OFS_IRQ);
    ena_d   = io_wdata[1:0];
    base_d  = io_wdata[BASE_W-1:0];
    irq_d   = io_wdata[IRQ_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q  <= '0;
      base_q <= '0;
      irq_q  <= '0;
    end else begin
      if (wr_ena)  ena_q  <= ena_d;
      if (wr_base) base_q <= base_d;
      if (wr_irq)  irq_q  <= irq_d;
    end
  end

  always_comb begin
    io_rdata = 8'h00;
    unique case (io_addr)
      OFS_ID_LO: io_rdata = ID_LO;
      OFS_ID_HI: io_rdata = ID_HI;
      OFS_ENA:   io_rdata[1:0] = ena_q;
      OFS_BASE:  io_rdata[BASE_W-1:0] = base_q;
      OFS_IRQ:   io_rdata[IRQ_W-1:0] = irq_q;
      default:   io_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/win_decode.sv
module win_decode
  import optsel_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int WIN_LOG2 = 14
) (
  input  logic                       card_on,
  input  logic [ADDR_W-WIN_LOG2-1:0] base,
  input  logic [ADDR_W-1:0]          mem_addr,
  output logic [NUM_REGION-1:0]      win_sel,
  output logic [WIN_LOG2-1:0]        win_off,
  output logic                       fix_en,
  output logic [7:0]                 fix_data
);
  localparam int OFF_W  = WIN_LOG2;
  localparam int WIN_SZ = 1 << WIN_LOG2;
  localparam logic [OFF_W-1:0] PROM_LO = OFF_W'(WIN_SZ - 64);
  localparam logic [OFF_W-1:0] RSVD_LO = OFF_W'(WIN_SZ - 32);
  localparam logic [OFF_W-1:0] BRG_LO  = OFF_W'(WIN_SZ - 16);
  localparam logic [OFF_W-1:0] CTRL_AT = OFF_W'(WIN_SZ - 14);
  localparam logic [OFF_W-1:0] CMD_AT  = OFF_W'(WIN_SZ - 13);
  localparam logic [OFF_W-1:0] TAIL_LO = OFF_W'(WIN_SZ - 12);

  logic             hit;
  logic [OFF_W-1:0] off;
  logic [OFF_W-1:0] prom_rel;

  always_comb begin
    off      = mem_addr[OFF_W-1:0];
    hit      = card_on && (mem_addr[ADDR_W-1:OFF_W] == base);
    prom_rel = off - PROM_LO;
    win_sel  = '0;
    win_off  = '0;
    fix_en   = 1'b0;
    fix_data = 8'h00;
    if (hit) begin
      if (off < PROM_LO) begin
        win_sel[RG_RAM] = 1'b1;
        win_off         = off;
      end else if (off < RSVD_LO) begin
        if (off[0]) begin
          fix_en   = 1'b1;
          fix_data = 8'hFF;
        end else begin
          win_sel[RG_PROM] = 1'b1;
          win_off          = prom_rel >> 1;
        end
      end else if (off < BRG_LO || off >= TAIL_LO) begin
        win_sel[RG_RSVD] = 1'b1;
        fix_en           = 1'b1;
        win_off          = off - RSVD_LO;
      end else if (off == CTRL_AT) begin
        win_sel[RG_CTRL] = 1'b1;
      end else if (off == CMD_AT) begin
        win_sel[RG_CMD] = 1'b1;
      end else begin
        win_sel[RG_HOLD] = 1'b1;
        win_off          = {{(OFF_W-1){1'b0}}, off[0]};
      end
    end
  end
endmodule

// File: rtl/optsel_window.sv
module optsel_window
  import optsel_pkg::*;
#(
  parameter int         ADDR_W   = 20,
  parameter int         WIN_LOG2 = 14,
  parameter int         IRQ_W    = 4,
  parameter logic [7:0] ID_LO    = 8'hFD,
  parameter logic [7:0] ID_HI    = 8'h6A
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  io_cs,
  input  logic                  io_wr,
  input  logic [2:0]            io_addr,
  input  logic [7:0]            io_wdata,
  output logic [7:0]            io_rdata,
  input  logic [ADDR_W-1:0]     mem_addr,
  output logic                  card_on,
  output logic                  boot_rom_on,
  output logic [IRQ_W-1:0]      irq_sel,
  output logic [NUM_REGION-1:0] win_sel,
  output logic [WIN_LOG2-1:0]   win_off,
  output logic                  fix_en,
  output logic [7:0]            fix_data
);
  localparam int BASE_W = ADDR_W - WIN_LOG2;

  logic [1:0]        ena_q;
  logic [BASE_W-1:0] base_q;

  optsel_regs #(
    .BASE_W(BASE_W), .IRQ_W(IRQ_W), .ID_LO(ID_LO), .ID_HI(ID_HI)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .io_cs(io_cs), .io_wr(io_wr),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .ena_q(ena_q), .base_q(base_q), .irq_q(irq_sel)
  );

  assign card_on     = ena_q[ENA_CARD_BIT];
  assign boot_rom_on = ~ena_q[ENA_ROMOFF_BIT];

  win_decode #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_dec (
    .card_on(card_on), .base(base_q), .mem_addr(mem_addr),
    .win_sel(win_sel), .win_off(win_off),
    .fix_en(fix_en), .fix_data(fix_data)
  );
endmodule

// File: rtl/optsel_window_chk.sv
module optsel_window_chk #(
  parameter int ADDR_W   = 20,
  parameter int WIN_LOG2 = 14,
  parameter int IRQ_W    = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                io_cs,
  input logic                io_wr,
  input logic [2:0]          io_addr,
  input logic [7:0]          io_wdata,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic                card_on,
  input logic                boot_rom_on,
  input logic [IRQ_W-1:0]    irq_sel,
  input logic [5:0]          win_sel,
  input logic                fix_en,
  input logic [7:0]          fix_data
);
  // R7
  card_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !card_on |-> (win_sel == '0) && !fix_en);
  // R12
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_sel));
  // R9
  prom_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_sel[1] |-> !mem_addr[0]);
  // R10
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_sel[2] |-> fix_en && (fix_data == 8'h00));
  // R2
  ena_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_cs && io_wr && io_addr == 3'd2) |=>
      (card_on == $past(io_wdata[0])) && (boot_rom_on == !$past(io_wdata[1])));
  // R6
  unused_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_cs && io_wr && io_addr >= 3'd5) |=>
      $stable(card_on) && $stable(boot_rom_on) && $stable(irq_sel));
endmodule

bind optsel_window optsel_window_chk #(
  .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .IRQ_W(IRQ_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_cs(io_cs), .io_wr(io_wr),
  .io_addr(io_addr), .io_wdata(io_wdata), .mem_addr(mem_addr),
  .card_on(card_on), .boot_rom_on(boot_rom_on), .irq_sel(irq_sel),
  .win_sel(win_sel), .fix_en(fix_en), .fix_data(fix_data)
);

// File: tb/tb_optsel_window.sv
module tb_optsel_window;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_cs, io_wr;
  logic [2:0]  io_addr;
  logic [7:0]  io_wdata, io_rdata;
  logic [19:0] mem_addr;
  logic        card_on, boot_rom_on, fix_en;
  logic [3:0]  irq_sel;
  logic [5:0]  win_sel;
  logic [13:0] win_off;
  logic [7:0]  fix_data;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  optsel_window dut (
    .clk(clk), .rst_n(rst_n), .io_cs(io_cs), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr),
    .card_on(card_on), .boot_rom_on(boot_rom_on), .irq_sel(irq_sel),
    .win_sel(win_sel), .win_off(win_off), .fix_en(fix_en), .fix_data(fix_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    io_cs = 1'b1; io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_cs = 1'b0; io_wr = 1'b0;
  endtask

  task automatic io_read_chk(string req, logic [2:0] a, logic [7:0] exp);
    io_addr = a; io_cs = 1'b1; io_wr = 1'b0;
    #1 check(req, io_rdata, exp);
    io_cs = 1'b0;
  endtask

  // expected window decode from the requirement text
  task automatic win_chk(logic [13:0] o);
    logic [5:0]  es; logic [13:0] eo; logic ef; logic [7:0] ed;
    es = 0; eo = 0; ef = 0; ed = 0;
    if (o <= 14'h3FBF) begin es = 6'b000001; eo = o; end
    else if (o <= 14'h3FDF) begin
      if (o % 2 == 1) begin ef = 1; ed = 8'hFF; end
      else begin es = 6'b000010; eo = (o - 14'h3FC0) / 2; end
    end else if (o <= 14'h3FEF || o >= 14'h3FF4) begin es = 6'b000100; ef = 1; end
    else if (o <= 14'h3FF1) begin es = 6'b001000; eo = o - 14'h3FF0; end
    else if (o == 14'h3FF2) es = 6'b010000;
    else es = 6'b100000;
    mem_addr = {6'h33, o};
    #1;
    check("R8-R11 sel", win_sel, es);
    if (es[0]) check("R8 off", win_off, eo);
    if (es[1]) check("R9 even off", win_off, eo);
    if (es[3]) check("R11 hold off", win_off, eo);
    check("R9/R10 fix_en", fix_en, ef);
    if (ef) check("R9/R10 fix_data", fix_data, ed);
    check("R12 onehot", $countones(win_sel) <= 1, 1);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; io_cs = 0; io_wr = 0; io_addr = 0; io_wdata = 0; mem_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 reset state
    check("R5 card_on", card_on, 0);
    check("R5 boot_rom_on", boot_rom_on, 1);
    check("R5 irq_sel", irq_sel, 0);
    for (int a = 2; a < 5; a++) io_read_chk("R5 reg zero", 3'(a), 8'h00);
    mem_addr = 20'h00010; #1;
    check("R7 off at reset", {fix_en, win_sel}, 0);
    // R1 and R6: writes ignored
    for (int a = 0; a < 8; a++) if (a < 2 || a > 4) io_write(3'(a), 8'hA5);
    io_read_chk("R1 id lo", 3'd0, 8'hFD);
    io_read_chk("R1 id hi", 3'd1, 8'h6A);
    for (int a = 5; a < 8; a++) io_read_chk("R6 unused", 3'(a), 8'h00);
    check("R6 no side effect", {card_on, irq_sel}, 0);
    check("R6 rom on kept", boot_rom_on, 1);
    io_read_chk("R6 base untouched", 3'd3, 8'h00);
    // R2 enable register
    for (int v = 0; v < 4; v++) begin
      io_write(3'd2, 8'(v) | 8'hFC);
      io_read_chk("R2 readback", 3'd2, 8'(v));
      check("R2 card_on", card_on, v % 2);
      check("R2 boot_rom_on", boot_rom_on, 1 - v / 2);
    end
    // R4 irq selection
    for (int v = 0; v < 16; v++) begin
      io_write(3'd4, 8'(v) | 8'hF0);
      io_read_chk("R4 readback", 3'd4, 8'(v));
      check("R4 irq_sel", irq_sel, v);
    end
    // R3 and R7: every base value
    io_write(3'd2, 8'h01);
    for (int b = 0; b < 64; b++) begin
      io_write(3'd3, 8'(b) | 8'hC0);
      io_read_chk("R3 readback", 3'd3, 8'(b));
      mem_addr = 20'(b * 16384 + 256); #1;
      check("R3 hit", win_sel, 6'b000001);
      check("R8 off", win_off, 14'd256);
      mem_addr = 20'(((b ^ 1) * 16384) + 256); #1;
      check("R7 miss", {fix_en, win_sel}, 0);
    end
    // window sweep at base 0x33
    io_write(3'd3, 8'h33);
    win_chk(14'h0000); win_chk(14'h1234); win_chk(14'h3FBF);
    for (int o = 14'h3F80; o <= 14'h3FFF; o++) win_chk(14'(o));
    // R7 card disabled hides the window
    io_write(3'd2, 8'h00);
    for (int o = 14'h3FB0; o <= 14'h3FFF; o += 3) begin
      mem_addr = {6'h33, 14'(o)}; #1;
      check("R7 disabled", {fix_en, win_sel}, 0);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule